// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance and Vector Unit

This unit decides when a small 8-bit CPU core enters an exception handler and where the handler address is fetched from. It watches four causes: reset, an active-low non-maskable request, a software-interrupt strobe from the core, and an active-low maskable request. It keeps the two mask flags. The I flag gates only the maskable request. The X flag gates only the non-maskable request. The software interrupt is never masked.

The core pulses `ins_bound` at every instruction boundary. Requests are judged only on those cycles. When a cause is accepted, the unit raises `take` for one cycle and presents on `vec_addr` the address of the high byte of a two-byte vector. It also sets the entry masks. When the core pulses `rti`, the flags are reloaded from the stacked copy on `saved_i` and `saved_x`.

The non-maskable request is captured on its falling edge and held until it is served. The maskable request is a level and is never latched. A software strobe stays pending until it is taken. The priority order is reset, then non-maskable, then software, then maskable. Vector pairs rise from the maskable pair at the base address: maskable at FFF2, non-maskable at FFF4, software at FFF6, and reset at FFFE. The three pairs between software and reset are reserved for other exception causes.

Top module: `irq_vector_unit`

## Requirements
- R1: While `rst_n` is low, `take` is 0, `i_mask` and `x_mask` are both 1, and `vec_addr` is 16'hFFFE.
- R2: On the first clock edge after reset is released, `take` pulses for one cycle with `vec_addr` = 16'hFFFE, whether or not `ins_bound` is high. No other cause is taken on that edge.
- R3: At a boundary where `irq_n` is low, `i_mask` is 0 and no higher cause wins, the unit takes the maskable request with `vec_addr` = 16'hFFF2 and sets `i_mask`.
- R4: While `i_mask` is 1, a low `irq_n` produces no take.
- R5: A falling edge on `nmi_n` is latched. The latched request is taken at a boundary when `x_mask` is 0, whatever the value of `i_mask`. The take uses `vec_addr` = 16'hFFF4 and sets both `x_mask` and `i_mask`.
- R6: A latched non-maskable request stays pending while `x_mask` is 1. Holding `nmi_n` low does not create a second request.
- R7: A `swi_req` pulse is held pending. It is taken at the next boundary not claimed by a non-maskable request, regardless of both masks. The take uses `vec_addr` = 16'hFFF6 and sets `i_mask`.
- R8: When several causes are eligible at one boundary, the non-maskable request wins over software, and software wins over maskable. Each loser stays pending while its condition holds.
- R9: Apart from the reset take, `take` only rises on the edge that samples `ins_bound` high. `vec_addr` holds its value between takes.
- R10: An `rti` pulse loads `i_mask` from `saved_i` and `x_mask` from `saved_x`. If a take happens on the same edge, the entry masks from that take are applied on top of the restored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | Maskable request, active low, level |
| nmi_n | input | 1 | Non-maskable request, active low, falling edge |
| swi_req | input | 1 | Software interrupt strobe from the core |
| ins_bound | input | 1 | Instruction boundary pulse |
| rti | input | 1 | Return-from-interrupt pulse |
| saved_i | input | 1 | Stacked I flag to restore |
| saved_x | input | 1 | Stacked X flag to restore |
| take | output | 1 | One-cycle pulse when a cause is accepted |
| vec_addr | output | 16 | Address of the vector pair for the last accepted cause |
| i_mask | output | 1 | I flag, masks `irq_n` |
| x_mask | output | 1 | X flag, masks the non-maskable request |

## Verification
The bound checker checks on every cycle the rules that hold at a single take or restore:
- each non-reset take follows a sampled boundary;
- a maskable take only occurs after I was clear, and a non-maskable take only after X was clear;
- the entry flags are set after a take;
- an `rti` without a boundary loads the stacked flags.

Other behaviour depends on history, and only the bench's scenarios can show it:
- the arbitration order when several causes coincide;
- losers that stay pending across several boundaries;
- a held-low `nmi_n` that must not fire twice;
- the single reset take.

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int          AW       = 16,
  parameter logic [15:0] VEC_BASE = 16'hFFF2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_n,
  input  logic          nmi_n,
  input  logic          swi_req,
  input  logic          ins_bound,
  input  logic          rti,
  input  logic          saved_i,
  input  logic          saved_x,
  output logic          take,
  output logic [AW-1:0] vec_addr,
  output logic          i_mask,
  output logic          x_mask
);
  localparam logic [AW-1:0] V_IRQ = AW'(VEC_BASE);
  localparam logic [AW-1:0] V_NMI = AW'(VEC_BASE + 16'd2);
  localparam logic [AW-1:0] V_SWI = AW'(VEC_BASE + 16'd4);
  localparam logic [AW-1:0] V_RST = AW'(VEC_BASE + 16'd12);

  logic rst_pend, nmi_prev, nmi_pend, swi_pend;
  logic nmi_fall, swi_any, go_nmi, go_swi, go_irq, arb_ok;

  assign nmi_fall = nmi_prev & ~nmi_n;
  assign swi_any  = swi_pend | swi_req;
  assign arb_ok   = ~rst_pend & ins_bound;
  assign go_nmi   = arb_ok & nmi_pend & ~x_mask;
  assign go_swi   = arb_ok & ~go_nmi & swi_any;
  assign go_irq   = arb_ok & ~go_nmi & ~go_swi & ~irq_n & ~i_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pend <= 1'b1;
      nmi_prev <= 1'b1;
      nmi_pend <= 1'b0;
      swi_pend <= 1'b0;
      take     <= 1'b0;
      vec_addr <= V_RST;
      i_mask   <= 1'b1;
      x_mask   <= 1'b1;
    end else begin
      nmi_prev <= nmi_n;
      nmi_pend <= (nmi_pend & ~go_nmi) | nmi_fall;
      swi_pend <= swi_any & ~go_swi;
      rst_pend <= 1'b0;
      take     <= rst_pend | go_nmi | go_swi | go_irq;
      if (rst_pend)    vec_addr <= V_RST;
      else if (go_nmi) vec_addr <= V_NMI;
      else if (go_swi) vec_addr <= V_SWI;
      else if (go_irq) vec_addr <= V_IRQ;
      if (!rst_pend) begin
        i_mask <= (go_nmi | go_swi | go_irq) ? 1'b1 : (rti ? saved_i : i_mask);
        x_mask <= go_nmi ? 1'b1 : (rti ? saved_x : x_mask);
      end
    end
  end
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ins_bound,
  input logic        rti,
  input logic        saved_i,
  input logic        saved_x,
  input logic        take,
  input logic [15:0] vec_addr,
  input logic        i_mask,
  input logic        x_mask
);
  a_r9_take_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_addr != 16'hFFFE) |-> $past(ins_bound));
  a_r3_irq_sets_i: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_addr == 16'hFFF2) |-> i_mask);
  a_r4_irq_needs_clear_i: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_addr == 16'hFFF2) |-> !$past(i_mask));
  a_r5_nmi_sets_x: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_addr == 16'hFFF4) |-> (x_mask && i_mask));
  a_r6_nmi_needs_clear_x: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_addr == 16'hFFF4) |-> !$past(x_mask));
  a_r7_swi_sets_i: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_addr == 16'hFFF6) |-> i_mask);
  a_r10_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (rti && !ins_bound && !take && !$rose(rst_n)) |=> (i_mask == $past(saved_i) && x_mask == $past(saved_x)));
endmodule

bind irq_vector_unit irq_vector_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ins_bound(ins_bound), .rti(rti),
  .saved_i(saved_i), .saved_x(saved_x), .take(take),
  .vec_addr(vec_addr), .i_mask(i_mask), .x_mask(x_mask)
);

// File: tb/irq_vector_unit_tb.sv
module irq_vector_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic irq_n = 1'b1, nmi_n = 1'b1, swi_req = 1'b0, ins_bound = 1'b0;
  logic rti = 1'b0, saved_i = 1'b1, saved_x = 1'b1;
  logic take, i_mask, x_mask;
  logic [15:0] vec_addr;
  int n_chk = 0, n_bad = 0;

  logic m_rstp, m_np, m_npend, m_spend, m_take, m_i, m_x;
  logic [15:0] m_vec;

  always #2.5 clk = ~clk;

  irq_vector_unit u_dut (.clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
    .swi_req(swi_req), .ins_bound(ins_bound), .rti(rti), .saved_i(saved_i),
    .saved_x(saved_x), .take(take), .vec_addr(vec_addr), .i_mask(i_mask), .x_mask(x_mask));

  function automatic string tag_of(input logic [15:0] v);
    case (v)
      16'hFFF2: return "R3";
      16'hFFF4: return "R5";
      16'hFFF6: return "R7";
      16'hFFFE: return "R2";
      default:  return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_rstp = 1; m_np = 1; m_npend = 0; m_spend = 0; m_take = 0;
    m_i = 1; m_x = 1; m_vec = 16'hFFFE;
  endtask

  task automatic model_step();
    logic fall, sany, gn, gs, gi, ni, nx;
    fall = m_np & ~nmi_n;
    m_np = nmi_n;
    sany = m_spend | swi_req;
    gn = 0; gs = 0; gi = 0;
    if (m_rstp) begin
      m_take = 1; m_vec = 16'hFFFE; m_rstp = 0;
      m_npend = m_npend | fall; m_spend = sany;
    end else begin
      ni = rti ? saved_i : m_i;
      nx = rti ? saved_x : m_x;
      if (ins_bound) begin
        if (m_npend && !m_x) gn = 1;
        else if (sany) gs = 1;
        else if (!irq_n && !m_i) gi = 1;
      end
      m_take = gn | gs | gi;
      if (gn) begin m_vec = 16'hFFF4; ni = 1; nx = 1; end
      if (gs) begin m_vec = 16'hFFF6; ni = 1; end
      if (gi) begin m_vec = 16'hFFF2; ni = 1; end
      m_npend = (m_npend & ~gn) | fall;
      m_spend = sany & ~gs;
      m_i = ni; m_x = nx;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    model_step();
    check(tag_of(m_vec), {31'd0, take}, {31'd0, m_take});
    check(tag_of(m_vec), {16'd0, vec_addr}, {16'd0, m_vec});
    check("R10", {30'd0, i_mask, x_mask}, {30'd0, m_i, m_x});
  endtask

  task automatic idle();
    irq_n = 1; swi_req = 0; ins_bound = 0; rti = 0;
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R1", {16'd0, take, i_mask, x_mask, vec_addr[12:0]}, {16'd0, 3'b011, 13'h1FFE});
    rst_n = 1;
    ins_bound = 0;
    tick();
    check("R2", {31'd0, take}, 32'd1);
    tick();
    check("R2", {31'd0, take}, 32'd0);
    irq_n = 0; ins_bound = 1;
    tick();
    check("R4", {31'd0, take}, 32'd0);
    idle(); rti = 1; saved_i = 0; saved_x = 0;
    tick();
    check("R10", {30'd0, i_mask, x_mask}, 32'd0);
    idle(); nmi_n = 0;
    tick();
    irq_n = 0; swi_req = 1; ins_bound = 1;
    tick();
    check("R8", {15'd0, take, vec_addr}, {15'd0, 1'b1, 16'hFFF4});
    swi_req = 0;
    tick();
    check("R8", {15'd0, take, vec_addr}, {15'd0, 1'b1, 16'hFFF6});
    idle(); rti = 1; saved_i = 1; saved_x = 0;
    tick();
    idle(); ins_bound = 1;
    repeat (3) tick();
    check("R6", {31'd0, take}, 32'd0);
    idle(); nmi_n = 1; rti = 1; saved_i = 1; saved_x = 1;
    tick();
    idle(); nmi_n = 0;
    tick();
    ins_bound = 1;
    tick();
    check("R6", {31'd0, take}, 32'd0);
    idle(); rti = 1; saved_x = 0;
    tick();
    idle(); ins_bound = 1;
    tick();
    check("R5", {15'd0, take, vec_addr}, {15'd0, 1'b1, 16'hFFF4});
    idle(); nmi_n = 1;
    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      irq_n = ($urandom % 10) < 3 ? 1'b0 : 1'b1;
      if (($urandom % 16) == 0) nmi_n = ~nmi_n;
      swi_req = ($urandom % 20) == 0;
      ins_bound = ($urandom % 5) < 2;
      rti = ($urandom % 12) == 0;
      saved_i = ($urandom % 3) != 0 ? 1'b0 : 1'b1;
      saved_x = ($urandom % 2) == 0;
      tick();
    end
    idle();
    rst_n = 0;
    model_reset();
    @(negedge clk);
    check("R1", {31'd0, take}, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule